// File: doc/BRIEF.md
# Left-Aligned PWM Channel with Privileged Test Controls

This block produces one left-aligned pulse-width-modulated output. The system clock passes through a fixed prescaler. Two independent 8-bit scale counters then divide the prescaled clock. One of them is chosen to step an 8-bit channel counter. The counter restarts either when it matches a programmed period or when it wraps naturally at 255. The output goes high when the counter restarts and goes low when the counter reaches the duty value.

A small register bus gives access to the control, scale, period, duty, channel-counter and test registers. Writes take one cycle and reads are combinational. A debug-halt input, together with a freeze bit in the control register, can stop the channel while the device is halted.

A privileged test register holds three override bits. It can be written only while the special-mode input is high. While that input is low, the register reads and acts as zero. The three bits can:
- stop a counter write from clearing the counter,
- stop a period match from restarting the counter,
- stop a scale-register write from reloading its scale counter.

Top module: `lapwm_channel`

## Requirements
- R1: The test register has three control bits at positions 7, 6 and 5. Bit 7 disables the clear on counter write, bit 6 disables the period restart, and bit 5 disables the scale-counter load. Bits 4..0 always read as zero, and the register resets to 0x00.
- R2: A write to the test register takes effect only while `special_i` is high. While `special_i` is low, the register reads 0x00, its bits have no effect, and the stored bits are cleared.
- R3: With test bit 7 clear, any write to the counter address clears the channel counter to 0 on that clock edge, whatever the write data.
- R4: With test bit 7 set, a write to the counter address leaves the counter running as if no write had occurred.
- R5: With test bit 6 clear, a step taken while the counter equals the period restarts the counter at 0. With bit 6 set, the counter keeps counting past the period and wraps from 255 to 0.
- R6: With test bit 5 clear, writing scale register A or B also loads the matching scale counter with the written value. With bit 5 set, only the register changes.
- R7: When the freeze bit (control bit 1) is set and `halt_i` is high, the prescaler, scale counters and channel counter all hold. When the freeze bit is clear, the channel runs during halt.
- R8: The registered output `pwm_o` is set when the channel counter becomes 0. It is cleared when the counter becomes equal to duty, and clearing wins when both happen together. At all other times it holds.
- R9: The prescaler emits one pulse every PRE_DIV enabled clocks. A scale counter emits one tick every N prescaler pulses, where N is its register value and a value of 0 means 256. The channel counter advances once per tick of the selected scaler: control bit 2 = 0 selects A and 1 selects B.
- R10: Register map on `addr_i`: 0 is control (bit 0 enable, bit 1 freeze, bit 2 scaler select), 1 is scale A, 2 is scale B, 3 is period (reset 0xFF), 4 is duty (reset 0x80), 5 is the channel counter, 6 is the test register, and 7 reads zero. All other registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_i | input | 1 | Special-mode enable for test register access |
| halt_i | input | 1 | Debug-halt indication |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| pwm_o | output | 1 | PWM output |

## Verification
A register write is captured on the next rising edge, so a counter clear is visible on the counter readback from the following cycle. The output is registered from the next counter value, so it changes on the same edge as the counter. The test-register readback goes to zero in the same cycle that `special_i` falls, because it is a combinational read. The bench drives inputs on falling edges and steps a behavioural model on each rising edge. It compares the model with the counter readback and `pwm_o` four nanoseconds after every rising edge. Directed reads are sampled one nanosecond after a falling edge, once the address has settled.

// File: rtl/lapwm_pkg.sv
package lapwm_pkg;
  localparam int AW = 3;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_SCLA = 3'd1;
  localparam logic [AW-1:0] A_SCLB = 3'd2;
  localparam logic [AW-1:0] A_PER  = 3'd3;
  localparam logic [AW-1:0] A_DUTY = 3'd4;
  localparam logic [AW-1:0] A_CNT  = 3'd5;
  localparam logic [AW-1:0] A_TEST = 3'd6;

  localparam logic [DW-1:0] PER_RST  = 8'hFF;
  localparam logic [DW-1:0] DUTY_RST = 8'h80;

  typedef struct packed {
    logic sel_b;
    logic freeze;
    logic enable;
  } ctrl_t;

  typedef struct packed {
    logic no_clr;
    logic no_per;
    logic no_load;
  } tst_t;
endpackage

// File: rtl/lapwm_prescale.sv
module lapwm_prescale #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pulse
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    pulse = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (run) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lapwm_scaler.sv
module lapwm_scaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic         tick,
  output logic [W-1:0] count_o
);
  logic [W-1:0] sc_q, sc_d;

  always_comb begin
    tick = step && (sc_q == W'(1));
    sc_d = sc_q;
    if (load)      sc_d = load_val;
    else if (step) sc_d = tick ? reload_val : sc_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= '0;
    else        sc_q <= sc_d;
  end

  assign count_o = sc_q;
endmodule

// File: rtl/lapwm_counter.sv
module lapwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clr,
  input  logic         no_per,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty,
  output logic [W-1:0] cnt_o,
  output logic         pwm_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         pwm_q, pwm_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = (cnt_q == period && !no_per) ? '0 : cnt_q + W'(1);
    if (cnt_d == duty)    pwm_d = 1'b0;
    else if (cnt_d == '0) pwm_d = 1'b1;
    else                  pwm_d = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pwm_q <= pwm_d;
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = pwm_q;
endmodule

// File: rtl/lapwm_testreg.sv
module lapwm_testreg (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          special,
  input  logic          wr,
  input  logic [2:0]    wbits,
  output lapwm_pkg::tst_t eff_o
);
  import lapwm_pkg::*;
  tst_t tst_q, tst_d;

  always_comb begin
    tst_d = tst_q;
    if (!special) tst_d = '0;
    else if (wr)  tst_d = tst_t'(wbits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tst_q <= '0;
    else        tst_q <= tst_d;
  end

  assign eff_o = special ? tst_q : '0;
endmodule

// File: rtl/lapwm_channel.sv
module lapwm_channel #(
  parameter int PRE_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_i,
  input  logic       halt_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       pwm_o
);
  import lapwm_pkg::*;
  localparam int NSC = 2;

  ctrl_t        ctrl_q, ctrl_d;
  logic [DW-1:0] per_q, per_d, duty_q, duty_d;
  logic [DW-1:0] scl_q [NSC];
  logic [DW-1:0] scl_d [NSC];
  logic [DW-1:0] sc_cnt [NSC];
  logic [NSC-1:0] sc_tick;
  logic [DW-1:0] cnt_q;
  tst_t          tst;
  logic          run, pre_pulse, chan_step, cnt_clr;

  assign run       = ctrl_q.enable && !(ctrl_q.freeze && halt_i);
  assign chan_step = ctrl_q.sel_b ? sc_tick[1] : sc_tick[0];
  assign cnt_clr   = wr_en_i && addr_i == A_CNT && !tst.no_clr;

  always_comb begin
    ctrl_d = ctrl_q;
    per_d  = per_q;
    duty_d = duty_q;
    if (wr_en_i && addr_i == A_CTRL) ctrl_d = ctrl_t'(wdata_i[2:0]);
    if (wr_en_i && addr_i == A_PER)  per_d  = wdata_i;
    if (wr_en_i && addr_i == A_DUTY) duty_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= PER_RST;
      duty_q <= DUTY_RST;
    end else begin
      ctrl_q <= ctrl_d;
      per_q  <= per_d;
      duty_q <= duty_d;
    end
  end

  lapwm_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .pulse(pre_pulse)
  );

  for (genvar g = 0; g < NSC; g++) begin : g_scl
    localparam logic [AW-1:0] MY_ADDR = A_SCLA + AW'(g);
    logic wr_me;
    assign wr_me = wr_en_i && addr_i == MY_ADDR;

    always_comb begin
      scl_d[g] = scl_q[g];
      if (wr_me) scl_d[g] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q[g] <= '0;
      else        scl_q[g] <= scl_d[g];
    end

    lapwm_scaler #(.W(DW)) u_sc (
      .clk(clk), .rst_n(rst_n), .step(pre_pulse),
      .load(wr_me && !tst.no_load), .load_val(wdata_i),
      .reload_val(scl_q[g]), .tick(sc_tick[g]), .count_o(sc_cnt[g])
    );
  end

  lapwm_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(chan_step), .clr(cnt_clr),
    .no_per(tst.no_per), .period(per_q), .duty(duty_q),
    .cnt_o(cnt_q), .pwm_o(pwm_o)
  );

  lapwm_testreg u_tst (
    .clk(clk), .rst_n(rst_n), .special(special_i),
    .wr(wr_en_i && addr_i == A_TEST), .wbits(wdata_i[7:5]), .eff_o(tst)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {5'b0, ctrl_q};
      A_SCLA:  rdata_o = scl_q[0];
      A_SCLB:  rdata_o = scl_q[1];
      A_PER:   rdata_o = per_q;
      A_DUTY:  rdata_o = duty_q;
      A_CNT:   rdata_o = cnt_q;
      A_TEST:  rdata_o = {tst, 5'b0};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lapwm_checker.sv
module lapwm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       special_i,
  input logic       halt_i,
  input logic       wr_en_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       pwm_o,
  input logic [7:0] cnt,
  input logic [7:0] duty,
  input logic [7:0] period,
  input logic [2:0] tst,
  input logic [2:0] ctrl,
  input logic [7:0] sca,
  input logic       step
);
  assert_test_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_i && addr_i == 3'd6) |-> rdata_o == 8'h00);

  assert_test_low_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 3'd6) |-> rdata_o[4:0] == 5'b0);

  assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 3'd5 && !tst[2]) |=> cnt == 8'h00);

  assert_cnt_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 3'd5 && tst[2] && !step) |=> $stable(cnt));

  assert_period_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == period && !tst[1] && !(wr_en_i && addr_i == 3'd5)) |=> cnt == 8'h00);

  assert_scale_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 3'd1 && !tst[0]) |=> sca == $past(wdata_i));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1] && halt_i && !wr_en_i) |=> $stable(cnt));

  assert_duty_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == duty && $stable(duty)) |-> !pwm_o);
endmodule

bind lapwm_channel lapwm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .special_i(special_i), .halt_i(halt_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .pwm_o(pwm_o), .cnt(cnt_q), .duty(duty_q), .period(per_q),
  .tst(tst), .ctrl(ctrl_q), .sca(sc_cnt[0]), .step(chan_step)
);

// File: tb/lapwm_channel_bench.sv
module lapwm_channel_bench;
  localparam int PRE = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic special_i = 1'b0, halt_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0] addr_i = 3'd5;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic pwm_o;

  int n_chk = 0, n_fail = 0;
  string cur = "R10";
  bit done = 0;

  lapwm_channel #(.PRE_DIV(PRE)) u_lapwm_channel (.*);

  always #10 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ctrl, m_sc[2], m_scl[2], m_per, m_duty, m_cnt, m_pwm, m_tst, m_pre;
  bit m_live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_sc = '{0, 0}; m_scl = '{0, 0}; m_per = 255; m_duty = 128;
      m_cnt = 0; m_pwm = 0; m_tst = 0; m_pre = 0; m_live = 1;
    end else begin
      int run, pt, tk[2], stp, eff, a, d;
      a = addr_i; d = wdata_i;
      eff = special_i ? m_tst : 0;
      run = (m_ctrl & 1) && !((m_ctrl & 2) && halt_i);
      pt = run && (m_pre == PRE - 1);
      if (run) m_pre = (m_pre == PRE - 1) ? 0 : m_pre + 1;
      for (int i = 0; i < 2; i++) begin
        tk[i] = pt && (m_sc[i] == 1);
        if (wr_en_i && a == i + 1 && !(eff & 1)) m_sc[i] = d;
        else if (pt) m_sc[i] = tk[i] ? m_scl[i] : (m_sc[i] + 255) % 256;
      end
      stp = (m_ctrl & 4) ? tk[1] : tk[0];
      if (wr_en_i && a == 5 && !(eff & 4)) m_cnt = 0;
      else if (stp) m_cnt = (m_cnt == m_per && !(eff & 2)) ? 0 : (m_cnt + 1) % 256;
      if (m_cnt == m_duty) m_pwm = 0;
      else if (m_cnt == 0) m_pwm = 1;
      if (!special_i) m_tst = 0;
      else if (wr_en_i && a == 6) m_tst = d >> 5;
      if (wr_en_i) begin
        case (a)
          0: m_ctrl = d & 7;
          1: m_scl[0] = d;
          2: m_scl[1] = d;
          3: m_per = d;
          4: m_duty = d;
          default: ;
        endcase
      end
    end
    #4;
    if (rst_n && m_live && !done) begin
      if (addr_i == 3'd5) check(cur, rdata_o, m_cnt);
      check(cur, pwm_o, m_pwm);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 3'(a); wdata_i = 8'(d);
    @(negedge clk);
    wr_en_i = 1'b0; addr_i = 3'd5;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    addr_i = 3'(a);
    #1 v = rdata_o;
    @(negedge clk);
    addr_i = 3'd5;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v, v2;
    bit seen;
    #55 rst_n = 1'b1;
    // reset values
    rd(6, v); check("R1 test reset", v, 0);
    rd(3, v); check("R10 period reset", v, 255);
    rd(4, v); check("R10 duty reset", v, 128);
    rd(0, v); check("R10 ctrl reset", v, 0);
    rd(7, v); check("R10 unused addr", v, 0);
    check("R8 output after reset", pwm_o, 1);

    cur = "R8";
    wr(1, 1); wr(3, 5); wr(4, 2); wr(0, 1);
    idle(60);
    cur = "R9";
    wr(1, 3); idle(80);
    wr(1, 0); idle(1100);
    wr(2, 2); wr(0, 5); idle(60);
    rd(2, v); check("R10 scale B readback", v, 2);
    wr(0, 1); wr(1, 1);

    cur = "R2";
    wr(6, 8'hE0); rd(6, v); check("R2 write ignored when special low", v, 0);
    special_i = 1'b1;
    rd(6, v); check("R2 still zero after raising special", v, 0);
    cur = "R1";
    wr(6, 8'hFF); rd(6, v); check("R1 only top three bits", v, 8'hE0);
    cur = "R2";
    @(negedge clk); special_i = 1'b0;
    rd(6, v); check("R2 reads zero when special low", v, 0);
    @(negedge clk); special_i = 1'b1;
    rd(6, v); check("R2 cleared after special dropped", v, 0);

    cur = "R3";
    idle(7);
    wr(5, 8'h77); #1 check("R3 counter cleared by write", rdata_o, 0);
    idle(20);

    cur = "R4";
    wr(6, 8'h80); idle(5);
    wr(5, 8'h00); idle(30);

    cur = "R5";
    wr(6, 8'h40);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (rdata_o == 8'd6) seen = 1;
    end
    check("R5 counter passes period with restart disabled", seen, 1);
    idle(560);
    wr(6, 8'h00); idle(40);

    cur = "R6";
    wr(6, 8'h20); wr(1, 4); idle(40);
    wr(6, 8'h00); wr(1, 2); idle(40);
    wr(1, 1);

    cur = "R7";
    wr(0, 3); halt_i = 1'b1;
    rd(5, v); idle(20); rd(5, v2);
    check("R7 frozen during halt", v2, v);
    wr(0, 1);
    idle(10); rd(5, v2);
    check("R7 runs during halt when freeze clear", (v2 != v), 1);
    halt_i = 1'b0; idle(20);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule